// File: doc/BRIEF.md
# Alarm Change Interrupt Controller

This block collects a vector of alarm status levels and a vector of single-cycle counter-overflow events, and drives a single interrupt line. It registers each level alarm on every clock, so the status that software reads always follows the live condition. It raises the interrupt whenever any registered level changes in either direction. An overflow event also raises the interrupt and sets a sticky overflow bit.

Software reads the block through a simple strobe-and-address port. The level status register reads the current levels and is never cleared by a read. The overflow register reads the sticky bits and clears them on the read. A read of either status register drops the interrupt. A new change or overflow in the same cycle as the read keeps the interrupt raised. A synchronous soft reset and the asynchronous hardware reset both return all status and the interrupt to zero.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After hardware reset, irq_o is 0 and both status registers read as 0.
- R2: A level input that goes from 0 to 1, relative to the registered status, sets irq_o at the next clock edge. The level status register (address 0) then shows the alarm in bit i for input i.
- R3: A level input that goes from 1 to 0, relative to the registered status, also sets irq_o at the next clock edge.
- R4: A read (rd_en_i=1) at address 0 or address 1, with no new change or overflow in that cycle, clears irq_o at that clock edge.
- R5: Reading the level status register does not alter it. A repeated read returns the same levels while the inputs stay the same.
- R6: An overflow event on ovf_evt_i[j] sets overflow status bit j (address 1, bit j) and sets irq_o at the next edge.
- R7: A read at address 1 returns the sticky overflow bits and then clears them. A read at address 0 leaves them set.
- R8: A level change or overflow event in the same cycle as a status read keeps irq_o at 1. An overflow event that coincides with a read of address 1 leaves its bit set.
- R9: soft_rst_i=1 clears the level status, the overflow bits, irq_o and rd_data_o at the next edge.
- R10: A read at any address other than 0 or 1 returns zero and leaves irq_o unchanged.
- R11: With levels stable, no overflow event and no status read, irq_o keeps its value.
- R12: rd_data_o is loaded at the edge where rd_en_i is 1 and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | Synchronous software reset of status and interrupt |
| lvl_i | input | NUM_LVL | Live alarm condition levels |
| ovf_evt_i | input | NUM_OVF | Single-cycle counter-overflow event pulses |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address: 0 level status, 1 overflow status |
| rd_data_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A registered level copy that lags or leads the input would show up in two places. irq_o would miss an edge, or would fire a cycle late, on the very next clock after lvl_i moves. A following read of address 0 would also return the wrong level. If the clear-on-read is wired to the wrong register, the second read of address 1 returns non-zero, or a read of address 0 wipes overflow bits. Either fault shows within two reads. A wrong priority between a new event and a read clear leaves irq_o low one cycle after the coinciding read.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int unsigned RA_LVL = 0;
  localparam int unsigned RA_OVF = 1;
endpackage

// File: rtl/alarm_lvl_track.sv
module alarm_lvl_track #(
  parameter int unsigned NUM_LVL = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               srst_i,
  input  logic [NUM_LVL-1:0] lvl_i,
  output logic [NUM_LVL-1:0] st_o,
  output logic               chg_o
);
  logic [NUM_LVL-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '0;
    else if (srst_i) st_q <= '0;
    else             st_q <= lvl_i;
  end

  // any bit differing from last registered copy is an edge, either direction
  assign chg_o = !srst_i && ((lvl_i ^ st_q) != '0);
  assign st_o  = st_q;
endmodule

// File: rtl/alarm_ovf_latch.sv
module alarm_ovf_latch #(
  parameter int unsigned NUM_OVF = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               srst_i,
  input  logic [NUM_OVF-1:0] evt_i,
  input  logic               clr_i,
  output logic [NUM_OVF-1:0] ovf_o,
  output logic               set_o
);
  logic [NUM_OVF-1:0] ovf_q;

  // new event wins over clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovf_q <= '0;
    else if (srst_i) ovf_q <= '0;
    else             ovf_q <= (clr_i ? '0 : ovf_q) | evt_i;
  end

  assign set_o = !srst_i && (evt_i != '0);
  assign ovf_o = ovf_q;

  a_r8_evt_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && clr_i && evt_i != '0) |=> ((ovf_q & $past(evt_i)) == $past(evt_i)));
  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && clr_i && evt_i == '0) |=> (ovf_q == '0));
endmodule

// File: rtl/alarm_irq_gen.sv
module alarm_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic lvl_chg_i,
  input  logic ovf_set_i,
  input  logic rd_clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      irq_q <= 1'b0;
    else if (srst_i)                  irq_q <= 1'b0;
    else if (lvl_chg_i || ovf_set_i)  irq_q <= 1'b1;
    else if (rd_clr_i)                irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  a_r2_r3_change_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && lvl_chg_i) |=> irq_o);
  a_r6_ovf_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && ovf_set_i) |=> irq_o);
  a_r4_read_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && rd_clr_i && !lvl_chg_i && !ovf_set_i) |=> !irq_o);
  a_r11_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !rd_clr_i && !lvl_chg_i && !ovf_set_i) |=> $stable(irq_o));
endmodule

// File: rtl/alarm_rd_port.sv
module alarm_rd_port #(
  parameter int unsigned NUM_LVL = 6,
  parameter int unsigned NUM_OVF = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               srst_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic [NUM_LVL-1:0] lvl_st_i,
  input  logic [NUM_OVF-1:0] ovf_st_i,
  output logic               stat_rd_o,
  output logic               ovf_rd_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  import alarm_irq_pkg::*;

  logic              sel_lvl, sel_ovf;
  logic [DATA_W-1:0] data_d, data_q;

  assign sel_lvl   = (rd_addr_i == ADDR_W'(RA_LVL));
  assign sel_ovf   = (rd_addr_i == ADDR_W'(RA_OVF));
  assign stat_rd_o = rd_en_i && (sel_lvl || sel_ovf);
  assign ovf_rd_o  = rd_en_i && sel_ovf;

  always_comb begin
    data_d = '0;
    if (sel_lvl)      data_d[NUM_LVL-1:0] = lvl_st_i;
    else if (sel_ovf) data_d[NUM_OVF-1:0] = ovf_st_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (srst_i)  data_q <= '0;
    else if (rd_en_i) data_q <= data_d;
  end

  assign rd_data_o = data_q;

  a_r12_data_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !rd_en_i) |=> $stable(rd_data_o));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int unsigned NUM_LVL = 6,
  parameter int unsigned NUM_OVF = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic [NUM_LVL-1:0] lvl_i,
  input  logic [NUM_OVF-1:0] ovf_evt_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o
);
  import alarm_irq_pkg::*;

  logic [NUM_LVL-1:0] lvl_st;
  logic [NUM_OVF-1:0] ovf_st;
  logic lvl_chg, ovf_set, stat_rd, ovf_rd;

  alarm_lvl_track #(.NUM_LVL(NUM_LVL)) u_lvl (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(soft_rst_i),
    .lvl_i(lvl_i), .st_o(lvl_st), .chg_o(lvl_chg)
  );

  alarm_ovf_latch #(.NUM_OVF(NUM_OVF)) u_ovf (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(soft_rst_i),
    .evt_i(ovf_evt_i), .clr_i(ovf_rd), .ovf_o(ovf_st), .set_o(ovf_set)
  );

  alarm_rd_port #(.NUM_LVL(NUM_LVL), .NUM_OVF(NUM_OVF), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(soft_rst_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .lvl_st_i(lvl_st), .ovf_st_i(ovf_st),
    .stat_rd_o(stat_rd), .ovf_rd_o(ovf_rd), .rd_data_o(rd_data_o)
  );

  alarm_irq_gen u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(soft_rst_i),
    .lvl_chg_i(lvl_chg), .ovf_set_i(ovf_set), .rd_clr_i(stat_rd), .irq_o(irq_o)
  );

  a_r9_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!irq_o && ovf_st == '0 && lvl_st == '0 && rd_data_o == '0));
  a_r5_read_keeps_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && rd_en_i && rd_addr_i == ADDR_W'(RA_LVL) && lvl_i == lvl_st)
    |=> (lvl_st == $past(lvl_st)));
endmodule

// File: tb/alarm_irq_ctrl_tb_top.sv
module alarm_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 6;
  localparam int NO = 3;
  localparam int DW = 8;
  localparam int AW = 2;

  typedef struct {
    logic          irq;
    logic [DW-1:0] data;
    bit            chk_data;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          srst = 1'b0;
  logic [NL-1:0] lvl = '0;
  logic [NO-1:0] ovf = '0;
  logic          rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  exp_t q[$];

  // reference state from the requirements
  logic [NL-1:0] m_lvl = '0;
  logic [NO-1:0] m_ovf = '0;
  logic          m_irq = 1'b0;
  logic [DW-1:0] m_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_irq_ctrl #(.NUM_LVL(NL), .NUM_OVF(NO), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(srst), .lvl_i(lvl), .ovf_evt_i(ovf),
    .rd_en_i(rd), .rd_addr_i(addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic step(input logic [NL-1:0] l, input logic [NO-1:0] o, input logic r,
                      input logic [AW-1:0] a, input logic s, input string tag);
    exp_t e;
    logic evt;
    @(negedge clk);
    lvl = l; ovf = o; rd = r; addr = a; srst = s;
    if (s) begin
      m_lvl = '0; m_ovf = '0; m_irq = 1'b0; m_data = '0;
    end else begin
      evt = (l != m_lvl) || (o != '0);
      if (r) begin
        m_data = '0;
        if (a == 0) m_data[NL-1:0] = m_lvl;
        else if (a == 1) m_data[NO-1:0] = m_ovf;
      end
      m_ovf = ((r && a == 1) ? '0 : m_ovf) | o;
      if (evt) m_irq = 1'b1;
      else if (r && a < 2) m_irq = 1'b0;
      m_lvl = l;
    end
    e.irq = m_irq; e.data = m_data; e.chk_data = r || s; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare just after each edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (irq !== e.irq) begin
        n_bad++;
        $display("FAIL %s irq_o act=%b exp=%b", e.tag, irq, e.irq);
      end
      if (e.chk_data) begin
        n_vec++;
        if (rd_data !== e.data) begin
          n_bad++;
          $display("FAIL %s rd_data_o act=%h exp=%h", e.tag, rd_data, e.data);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1: reset state seen on the ports before any read
    n_vec++;
    if (irq !== 1'b0 || rd_data !== '0) begin
      n_bad++;
      $display("FAIL R1 act irq=%b data=%h exp irq=0 data=00", irq, rd_data);
    end
    rst_n = 1'b1;
    step('0, '0, 1, 2'd0, 0, "R1");
    step('0, '0, 1, 2'd1, 0, "R1");
    step('0, '0, 0, 2'd0, 0, "R11");
    step('0, '0, 0, 2'd0, 0, "R11");
    // rising edge
    step(6'b000001, '0, 0, 2'd0, 0, "R2");
    step(6'b000001, '0, 0, 2'd0, 0, "R11");
    step(6'b000001, '0, 1, 2'd0, 0, "R4");
    step(6'b000001, '0, 1, 2'd0, 0, "R5");
    step(6'b000001, '0, 0, 2'd0, 0, "R12");
    step(6'b000001, '0, 0, 2'd0, 0, "R11");
    // multi-bit rising pattern
    step(6'b101011, '0, 0, 2'd0, 0, "R2");
    step(6'b101011, '0, 1, 2'd0, 0, "R5");
    // falling edge
    step(6'b100010, '0, 0, 2'd0, 0, "R3");
    step(6'b100010, '0, 1, 2'd2, 0, "R10");
    step(6'b100010, '0, 1, 2'd3, 0, "R10");
    step(6'b100010, '0, 1, 2'd1, 0, "R4");
    step(6'b100010, '0, 1, 2'd0, 0, "R5");
    step(6'b000000, '0, 0, 2'd0, 0, "R3");
    step(6'b000000, '0, 1, 2'd0, 0, "R4");
    // overflow
    step('0, 3'b010, 0, 2'd0, 0, "R6");
    step('0, '0, 1, 2'd0, 0, "R7");
    step('0, '0, 1, 2'd1, 0, "R7");
    step('0, '0, 1, 2'd1, 0, "R7");
    step('0, 3'b101, 0, 2'd0, 0, "R6");
    step('0, '0, 1, 2'd1, 0, "R6");
    // coincident event and read
    step(6'b000100, '0, 0, 2'd0, 0, "R2");
    step(6'b000000, '0, 1, 2'd0, 0, "R8");
    step(6'b000000, '0, 1, 2'd0, 0, "R4");
    step('0, 3'b001, 0, 2'd0, 0, "R6");
    step('0, 3'b100, 1, 2'd1, 0, "R8");
    step('0, '0, 1, 2'd1, 0, "R8");
    step('0, 3'b010, 1, 2'd0, 0, "R8");
    step('0, '0, 1, 2'd1, 0, "R7");
    // soft reset
    step(6'b111111, 3'b011, 0, 2'd0, 0, "R9");
    step(6'b111111, '0, 1, 2'd0, 1, "R9");
    step('0, '0, 1, 2'd1, 0, "R9");
    step('0, '0, 1, 2'd0, 0, "R9");
    step(6'b010101, '0, 0, 2'd0, 0, "R2");
    step(6'b010101, '0, 1, 2'd3, 0, "R10");
    step(6'b010101, '0, 1, 2'd0, 0, "R12");
    step(6'b010101, '0, 0, 2'd0, 0, "R12");
    step(6'b010101, '0, 0, 2'd0, 0, "R11");
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule